// File: doc/BRIEF.md
# Bit-Layer Signed-Digit Dot-Product Accumulator

This block forms the dot product of an input vector with a weight vector whose weights have been rewritten offline as signed digits, each digit being -1, 0 or +1. It does not walk through the weights one at a time. It walks through the digit planes, from the most significant plane down to plane zero. Within a plane, every nonzero digit (a pulse) adds or subtracts one input element in one cycle. Between planes, the single accumulator doubles. No multiplier is used. The run time equals the number of pulses plus one cycle for each plane that closes with an explicit marker.

The weights reach the block as a stream of entries, one per cycle, ordered plane by plane. A pulse entry carries a count of skipped zero positions and a sign bit. A marker entry closes the current plane. A plane whose last pulse sits on position N-1 closes by itself and has no marker. The input vector is presented in parallel and held steady while a run is in progress. A start strobe opens a run. A one-cycle done strobe closes it, and the signed result is then held until the next start.

Top module: `bl_pulse_acc`

## Requirements
- R1: While reset is applied and after it is released, busy, done and entReady are 0 and result is 0.
- R2: A start seen while idle clears the accumulator, selects plane LAYERS-1 at position 0 and raises busy on the next cycle. A start seen while busy has no effect.
- R3: A pulse entry (entValid=1, entEol=0) addresses index = position + entRun. It adds x[index] when entNeg=0 and subtracts it when entNeg=1. The position then moves to index+1, so indices ascend within a plane.
- R4: A marker entry (entEol=1) closes the plane, and its entRun and entNeg are ignored. If the closed plane is not plane 0, the accumulator doubles. A plane with no pulses therefore costs exactly one cycle.
- R5: A pulse that lands on index N-1 closes its plane in the same cycle, with the doubling applied after the add or subtract. The next entry belongs to the next plane, starting at position 0.
- R6: No doubling follows plane 0. Closing plane 0 drops busy, pulses done high for exactly one cycle, and leaves result unchanged until the next start.
- R7: The number of busy cycles of a run equals the number of entries consumed plus the number of cycles with entValid low.
- R8: The result equals the sum over planes i of 2^i times the sum over j of d_ij·x_j, in two's complement, without overflow even when every digit is ±1 and every input is at its most negative value.
- R9: A cycle with entValid low while busy leaves the accumulator and the position unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new run (taken only when idle) |
| xVec | input | N*XW | Input vector, element j at bits [j*XW +: XW], signed |
| entValid | input | 1 | A stream entry is present this cycle |
| entRun | input | RW | Zero positions skipped before the pulse |
| entNeg | input | 1 | Pulse sign: 1 subtracts, 0 adds |
| entEol | input | 1 | Entry is an end-of-plane marker |
| entReady | output | 1 | Entries are consumed this cycle (equals busy) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle strobe after plane 0 closes |
| result | output | AW | Signed accumulator value |

## Verification
Almost any fault in the plane counter or the position register shows up at the ports as a wrong result at done, or as done arriving too early or too late. Both are compared on the very cycle done rises, using a busy-cycle count derived from the stream. A lost or extra doubling scales the result by a power of two. A wrong position moves a coefficient onto a neighbouring input element, so the input values are chosen distinct. Stall cycles and a start during a run are mixed into the stream, so that a fault which advances state on an empty cycle also changes the sum or the cycle count.

// File: rtl/bl_pkg.sv
package bl_pkg;

  // strobes from the layer control to the accumulator datapath
  typedef struct packed {
    logic clear;   // zero the accumulator
    logic accum;   // add or subtract the selected element
    logic negate;  // subtract instead of add
    logic dbl;     // double after the optional add (plane boundary)
  } acc_ctrl_t;

endpackage

// File: rtl/bl_layer_ctrl.sv
module bl_layer_ctrl
  import bl_pkg::*;
#(
  parameter int N      = 16,
  parameter int LAYERS = 8,
  parameter int RW     = (N > 1) ? $clog2(N) : 1,
  parameter int IW     = $clog2(N) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          entValid,
  input  logic [RW-1:0] entRun,
  input  logic          entNeg,
  input  logic          entEol,
  output acc_ctrl_t     ctrl,
  output logic [IW-1:0] selIdx,
  output logic          busy,
  output logic          done
);

  localparam int LW = (LAYERS > 1) ? $clog2(LAYERS) : 1;
  localparam logic [LW-1:0] TOP_LAYER = LW'(LAYERS - 1);
  localparam logic [IW-1:0] LAST_POS  = IW'(N - 1);

  logic          running;
  logic          doneQ;
  logic [LW-1:0] layerIdx;
  logic [IW-1:0] pos;

  logic          take;
  logic          pulse;
  logic          atLastPos;
  logic          layerEnd;
  logic          lastLayer;
  logic [IW-1:0] idx;

  always_comb begin
    take      = running & entValid;
    idx       = pos + IW'(entRun);
    pulse     = take & ~entEol;
    atLastPos = (idx == LAST_POS);
    layerEnd  = take & (entEol | atLastPos);
    lastLayer = (layerIdx == '0);

    ctrl.clear  = start & ~running;
    ctrl.accum  = pulse;
    ctrl.negate = entNeg;
    ctrl.dbl    = layerEnd & ~lastLayer;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running  <= 1'b0;
      doneQ    <= 1'b0;
      layerIdx <= '0;
      pos      <= '0;
    end else begin
      doneQ <= 1'b0;
      if (start && !running) begin
        running  <= 1'b1;
        layerIdx <= TOP_LAYER;
        pos      <= '0;
      end else if (take) begin
        if (layerEnd) begin
          pos <= '0;
          if (lastLayer) begin
            running <= 1'b0;
            doneQ   <= 1'b1;
          end else begin
            layerIdx <= layerIdx - 1'b1;
          end
        end else begin
          pos <= idx + 1'b1;
        end
      end
    end
  end

  assign selIdx = idx;
  assign busy   = running;
  assign done   = doneQ;

endmodule

// File: rtl/bl_acc_path.sv
module bl_acc_path
  import bl_pkg::*;
#(
  parameter int N  = 16,
  parameter int XW = 8,
  parameter int AW = 32,
  parameter int IW = $clog2(N) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N*XW-1:0]      xVec,
  input  acc_ctrl_t            ctrl,
  input  logic [IW-1:0]        selIdx,
  output logic signed [AW-1:0] acc
);

  logic signed [XW-1:0] xArr [N];
  logic signed [XW-1:0] xSel;
  logic signed [AW-1:0] xExt;
  logic signed [AW-1:0] sum;
  logic signed [AW-1:0] accNext;

  for (genvar k = 0; k < N; k++) begin : g_unpack
    assign xArr[k] = xVec[k*XW +: XW];
  end

  // an index past N-1 selects zero
  always_comb begin
    xSel = '0;
    for (int k = 0; k < N; k++) begin
      if (selIdx == IW'(k)) xSel = xArr[k];
    end
    xExt = AW'(xSel);
  end

  always_comb begin
    sum = acc;
    if (ctrl.accum) sum = ctrl.negate ? (acc - xExt) : (acc + xExt);
    accNext = ctrl.dbl ? (sum <<< 1) : sum;
    if (ctrl.clear) accNext = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= accNext;
  end

endmodule

// File: rtl/bl_pulse_acc.sv
module bl_pulse_acc
  import bl_pkg::*;
#(
  parameter int N      = 16,
  parameter int LAYERS = 8,
  parameter int XW     = 8,
  localparam int RW    = (N > 1) ? $clog2(N) : 1,
  localparam int IW    = $clog2(N) + 1,
  localparam int AW    = XW + LAYERS + $clog2(N) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [N*XW-1:0]      xVec,
  input  logic                 entValid,
  input  logic [RW-1:0]        entRun,
  input  logic                 entNeg,
  input  logic                 entEol,
  output logic                 entReady,
  output logic                 busy,
  output logic                 done,
  output logic signed [AW-1:0] result
);

  acc_ctrl_t     ctrl;
  logic [IW-1:0] selIdx;

  bl_layer_ctrl #(.N(N), .LAYERS(LAYERS), .RW(RW), .IW(IW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .entValid (entValid),
    .entRun   (entRun),
    .entNeg   (entNeg),
    .entEol   (entEol),
    .ctrl     (ctrl),
    .selIdx   (selIdx),
    .busy     (busy),
    .done     (done)
  );

  bl_acc_path #(.N(N), .XW(XW), .AW(AW), .IW(IW)) u_path (
    .clk    (clk),
    .rst_n  (rst_n),
    .xVec   (xVec),
    .ctrl   (ctrl),
    .selIdx (selIdx),
    .acc    (result)
  );

  assign entReady = busy;

endmodule

// File: rtl/bl_pulse_acc_chk.sv
module bl_pulse_acc_chk #(
  parameter int AW = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 entValid,
  input logic                 entEol,
  input logic                 entReady,
  input logic                 busy,
  input logic                 done,
  input logic signed [AW-1:0] result
);

  // R6: done lasts one cycle
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: done coincides with idle
  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !entReady));

  // R6: idle without start holds the result
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> (!busy && $stable(result)));

  // R2: start from idle clears and begins
  a_r2_start_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && result == '0));

  // R2: start while busy has no effect
  a_r2_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !entValid) |=> (busy && $stable(result)));

  // R9: empty cycles hold the accumulator
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !entValid) |=> $stable(result));

  // R4: a marker doubles, except after plane 0
  a_r4_marker_double: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && entValid && entEol) |=>
      (done ? $stable(result) : (result == ($past(result) <<< 1))));

endmodule

bind bl_pulse_acc bl_pulse_acc_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .entValid (entValid),
  .entEol   (entEol),
  .entReady (entReady),
  .busy     (busy),
  .done     (done),
  .result   (result)
);

// File: tb/test_bl_pulse_acc.sv
module test_bl_pulse_acc;

  localparam int N  = 5;
  localparam int L  = 6;
  localparam int XW = 8;
  localparam int RW = $clog2(N);
  localparam int AW = XW + L + $clog2(N) + 1;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 start = 1'b0;
  logic [N*XW-1:0]      xVec = '0;
  logic                 entValid = 1'b0;
  logic [RW-1:0]        entRun = '0;
  logic                 entNeg = 1'b0;
  logic                 entEol = 1'b0;
  logic                 entReady;
  logic                 busy;
  logic                 done;
  logic signed [AW-1:0] result;

  bl_pulse_acc #(.N(N), .LAYERS(L), .XW(XW)) i_bl_pulse_acc (
    .clk(clk), .rst_n(rst_n), .start(start), .xVec(xVec),
    .entValid(entValid), .entRun(entRun), .entNeg(entNeg), .entEol(entEol),
    .entReady(entReady), .busy(busy), .done(done), .result(result)
  );

  always #2 clk = ~clk;

  typedef struct {
    longint res;
    int     cyc;
    string  tag;
  } exp_t;

  exp_t sb[$];
  int   nChecks = 0;
  int   nFails  = 0;
  int   busyCnt = 0;
  int   pending = 0;
  bit   finished = 1'b0;

  int dig [L][N];
  int xs  [N];

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: pops the scoreboard when a run completes
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busyCnt++;
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R6 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(longint'(result) == e.res, {"R8 result ", e.tag}, longint'(result), e.res);
          chk(busyCnt == e.cyc, {"R7 cycles ", e.tag}, busyCnt, e.cyc);
          chk(!busy && !entReady, {"R6 idle at done ", e.tag}, busy, 0);
        end
        busyCnt = 0;
        pending--;
      end
    end
  end

  // driver: builds the stream from dig/xs, pushes the expectation, drives it
  task automatic runVec(input string tag, input int stallMax, input bit pokeStart);
    int     runQ[$];
    bit     negQ[$];
    bit     eolQ[$];
    int     stl[$];
    longint expv = 0;
    int     total = 0;
    longint held;
    exp_t   e;
    for (int i = L - 1; i >= 0; i--) begin
      int p = 0;
      bit implied = 1'b0;
      longint part = 0;
      for (int j = 0; j < N; j++) begin
        part += longint'(dig[i][j]) * longint'(xs[j]);
        if (dig[i][j] != 0) begin
          runQ.push_back(j - p); negQ.push_back(dig[i][j] < 0); eolQ.push_back(1'b0);
          p = j + 1;
          implied = (j == N - 1);
        end
      end
      if (!implied) begin
        // R4: fields of a marker carry junk on purpose
        runQ.push_back($urandom_range(0, N - 1)); negQ.push_back(1'($urandom_range(0, 1)));
        eolQ.push_back(1'b1);
      end
      expv += part * (longint'(1) << i);
    end
    for (int k = 0; k < runQ.size(); k++) begin
      int s = (stallMax > 0) ? $urandom_range(0, stallMax) : 0;
      stl.push_back(s);
      total += s + 1;
    end
    e.res = expv; e.cyc = total; e.tag = tag;
    sb.push_back(e);
    pending++;

    @(negedge clk);
    for (int j = 0; j < N; j++) xVec[j*XW +: XW] = XW'(xs[j]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && entReady && result == 0, {"R2 start clears ", tag}, longint'(result), 0);
    for (int k = 0; k < runQ.size(); k++) begin
      for (int s = 0; s < stl[k]; s++) begin
        entValid = 1'b0;
        entRun = RW'($urandom_range(0, N - 1));
        @(negedge clk);
      end
      entValid = 1'b1;
      entRun = RW'(runQ[k]);
      entNeg = negQ[k];
      entEol = eolQ[k];
      if (pokeStart && k == runQ.size() / 2) start = 1'b1; // R2 ignored when busy
      @(negedge clk);
      start = 1'b0;
    end
    entValid = 1'b0;
    entEol = 1'b0;
    while (busy) @(negedge clk);
    held = longint'(result);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(longint'(result) == held && !done, {"R6 hold ", tag}, longint'(result), held);
    end
  endtask

  task automatic setAll(input int dv, input int xv);
    for (int i = 0; i < L; i++) for (int j = 0; j < N; j++) dig[i][j] = dv;
    for (int j = 0; j < N; j++) xs[j] = xv;
  endtask

  task automatic randVec();
    for (int i = 0; i < L; i++) for (int j = 0; j < N; j++) dig[i][j] = $urandom_range(0, 2) - 1;
    for (int j = 0; j < N; j++) xs[j] = $urandom_range(0, 255) - 128;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!busy && !done && !entReady && result == 0, "R1 in reset", longint'(result), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !entReady && result == 0, "R1 after reset", longint'(result), 0);

    // R8 R5 R4 worked example: expect x0 + 27*x1 + 7*x2 + 2*x4
    setAll(0, 0);
    dig[5][1] = 1;
    dig[3][2] = 1;
    dig[2][1] = -1;
    dig[1][4] = 1;
    dig[0][0] = 1; dig[0][1] = -1; dig[0][2] = -1;
    xs[0] = 10; xs[1] = -3; xs[2] = 4; xs[3] = 9; xs[4] = -7;
    chk(10 + 27 * (-3) + 7 * 4 + 2 * (-7) == -57, "R8 example formula", -57, -57);
    runVec("example", 0, 1'b0);

    // R4 all planes empty: one cycle each
    setAll(0, 55);
    runVec("empty", 0, 1'b0);

    // R5 R8 extremes: every pulse ends on N-1
    setAll(1, -128);
    runVec("allpos_min", 0, 1'b0);
    setAll(-1, -128);
    runVec("allneg_min", 0, 1'b0);
    setAll(1, 127);
    runVec("allpos_max", 2, 1'b0);

    // R3 R9 random digits with stalls
    for (int t = 0; t < 12; t++) begin
      randVec();
      runVec($sformatf("rand%0d", t), (t % 3), 1'b0);
    end

    // R2 start during a run is ignored
    randVec();
    dig[L-1][0] = 1;
    runVec("poke", 1, 1'b1);

    repeat (4) @(negedge clk);
    chk(sb.size() == 0 && pending == 0, "R6 all runs completed", sb.size(), 0);
    summary();
  end

endmodule